// File: doc/BRIEF.md
# Feature-Bit Predicate Test Unit

This unit executes a test-feature operation. A 5-bit immediate picks one bit from the upper half of a 64-bit processor feature vector. The unit tests that bit for zero or non-zero, and turns the outcome into writes on two predicate-register write ports. The write rules depend on a compare type: plain, unconditional, and three parallel forms (AND, OR, OR-ANDCM). The qualifying predicate is read from a copy of the predicate file presented at the inputs. The unit also flags an illegal-operation fault when the two destinations name the same register.

The operation is accepted on a cycle with `in_valid` high. Its write-port results and fault flag appear registered on the next cycle with `out_valid`. The predicate file and fault handling sit outside the unit. Predicate register 0 is constant one, so no write port ever targets it.

Compare-type encoding on `ctype`: 0 plain, 1 unconditional, 2 parallel AND, 3 parallel OR, 4 parallel OR-ANDCM, 5 to 7 reserved. On `rel_nz`, 0 selects the zero test and 1 selects the non-zero test.

Top module: `tfp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `out_valid`, both write enables and `fault` at 0.
- R2: Results appear exactly one clock after the edge that samples `in_valid`=1. After an edge with `in_valid`=0, `out_valid`, both write enables and `fault` are 0.
- R3: The tested bit is `feat_vec[32 + sel_imm]`. Bits 0 to 31 of `feat_vec` never influence any output.
- R4: The qualifier is `pred_vals[qp_idx]`, except that `qp_idx`=0 always reads as 1.
- R5: Plain type (0) with the qualifier true works as follows. Zero test: port A targets `dest1` with data (bit==0), and port B targets `dest2` with the complement. Non-zero test: the zero test runs with the destinations swapped, so port A targets `dest2` with (bit==0) and port B targets `dest1` with (bit==1). With the qualifier false, nothing is written.
- R6: Unconditional type (1) always enables both ports. With the qualifier false, both data bits are 0. Otherwise the ports behave as for the plain type, including the swap.
- R7: Parallel AND (2): the test result is (bit==1) for non-zero and (bit==0) for zero, with no swap. When the qualifier is true and the result is false, both ports write 0. Otherwise there is no write.
- R8: Parallel OR (3): when the qualifier is true and the result is true, both ports write 1. Otherwise there is no write.
- R9: Parallel OR-ANDCM (4): when the qualifier is true and the result is true, port A (`dest1`) writes 1 and port B (`dest2`) writes 0. Otherwise there is no write.
- R10: For types 0 to 4, `fault` is 1 when `dest1`==`dest2` and either the qualifier is true or the type is unconditional. A faulting operation enables neither port.
- R11: A port whose target index is 0 is never enabled.
- R12: Reserved types 5 to 7 enable no port and raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| qp_idx | input | 6 | Qualifying predicate index |
| pred_vals | input | 64 | Current predicate register values |
| sel_imm | input | 5 | Feature selector, bit 32 + value |
| rel_nz | input | 1 | 1 = non-zero test, 0 = zero test |
| ctype | input | 3 | Compare type code |
| dest1 | input | 6 | First destination index |
| dest2 | input | 6 | Second destination index |
| feat_vec | input | 64 | Processor feature vector |
| out_valid | output | 1 | Registered result present |
| wr_en_a | output | 1 | Write enable, port A |
| wr_idx_a | output | 6 | Target index, port A |
| wr_data_a | output | 1 | Write data, port A |
| wr_en_b | output | 1 | Write enable, port B |
| wr_idx_b | output | 6 | Target index, port B |
| wr_data_b | output | 1 | Write data, port B |
| fault | output | 1 | Illegal-operation fault |

## Verification
Every compare type is driven with both test senses, with the selected bit both set and clear, and with the qualifier both true and false. This separates the swap-based plain and unconditional paths from the direct parallel ones. Patterns with equal destinations and a false qualifier separate the unconditional fault rule from the plain one. Destinations or qualifier at index 0 expose the write suppression and the constant-one read. Toggling only the low 32 feature bits shows that the selection window starts at bit 32. A long random run then mixes reserved codes, idle gaps and all of the above.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

    localparam logic [2:0] CT_PLAIN   = 3'd0;
    localparam logic [2:0] CT_UNCOND  = 3'd1;
    localparam logic [2:0] CT_PAR_AND = 3'd2;
    localparam logic [2:0] CT_PAR_OR  = 3'd3;
    localparam logic [2:0] CT_PAR_OAC = 3'd4;

    typedef enum logic [2:0] {
        K_PLAIN, K_UNCOND, K_PAND, K_POR, K_POAC, K_RSVD
    } kind_e;

    typedef struct packed {
        logic en;
        logic data;
    } pwr_t;

    function automatic kind_e decode_kind(input logic [2:0] code);
        case (code)
            CT_PLAIN:   return K_PLAIN;
            CT_UNCOND:  return K_UNCOND;
            CT_PAR_AND: return K_PAND;
            CT_PAR_OR:  return K_POR;
            CT_PAR_OAC: return K_POAC;
            default:    return K_RSVD;
        endcase
    endfunction

    function automatic logic uses_swap(input kind_e k);
        return (k == K_PLAIN) || (k == K_UNCOND);
    endfunction

endpackage

// File: rtl/tfp_select.sv
module tfp_select #(
    parameter int FEAT_W   = 64,
    parameter int IMM_W    = 5,
    parameter int SEL_BASE = 32
) (
    input  logic [FEAT_W-1:0] feat,
    input  logic [IMM_W-1:0]  imm,
    output logic              avail
);
    localparam int SEL_W = $clog2(FEAT_W);

    logic [SEL_W-1:0] bit_idx;

    always_comb begin
        bit_idx = SEL_W'(SEL_BASE) + SEL_W'(imm);
        avail   = feat[bit_idx];
    end
endmodule

// File: rtl/tfp_qual.sv
module tfp_qual #(
    parameter int NUM_PRED = 64,
    parameter int IDX_W    = 6
) (
    input  logic [NUM_PRED-1:0] pred_vals,
    input  logic [IDX_W-1:0]    qp_idx,
    output logic                qual
);
    always_comb begin
        if (qp_idx == '0) qual = 1'b1;
        else              qual = pred_vals[qp_idx];
    end
endmodule

// File: rtl/tfp_route.sv
module tfp_route
    import tfp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             qual,
    input  logic             avail,
    input  logic             rel_nz,
    input  logic [2:0]       ctype,
    input  logic [IDX_W-1:0] dest1,
    input  logic [IDX_W-1:0] dest2,
    output pwr_t             port_a,
    output pwr_t             port_b,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_b,
    output logic             flt
);
    kind_e kind;
    logic  swap;
    logic  zres;
    logic  pres;
    pwr_t  raw_a;
    pwr_t  raw_b;

    always_comb begin
        kind = decode_kind(ctype);
        swap = uses_swap(kind) && rel_nz;
        idx_a = swap ? dest2 : dest1;
        idx_b = swap ? dest1 : dest2;
        zres = ~avail;
        pres = rel_nz ? avail : ~avail;

        raw_a = '0;
        raw_b = '0;
        case (kind)
            K_PLAIN: begin
                raw_a = '{en: qual, data: zres};
                raw_b = '{en: qual, data: ~zres};
            end
            K_UNCOND: begin
                raw_a = '{en: 1'b1, data: qual & zres};
                raw_b = '{en: 1'b1, data: qual & ~zres};
            end
            K_PAND: begin
                raw_a = '{en: qual & ~pres, data: 1'b0};
                raw_b = '{en: qual & ~pres, data: 1'b0};
            end
            K_POR: begin
                raw_a = '{en: qual & pres, data: 1'b1};
                raw_b = '{en: qual & pres, data: 1'b1};
            end
            K_POAC: begin
                raw_a = '{en: qual & pres, data: 1'b1};
                raw_b = '{en: qual & pres, data: 1'b0};
            end
            default: begin
                raw_a = '0;
                raw_b = '0;
            end
        endcase

        flt = (kind != K_RSVD) && (dest1 == dest2) && (qual || kind == K_UNCOND);

        port_a      = raw_a;
        port_b      = raw_b;
        port_a.en   = raw_a.en & ~flt & (idx_a != '0);
        port_b.en   = raw_b.en & ~flt & (idx_b != '0);
    end
endmodule

// File: rtl/tfp_unit.sv
module tfp_unit
    import tfp_pkg::*;
#(
    parameter int NUM_PRED = 64,
    parameter int FEAT_W   = 64,
    parameter int IMM_W    = 5,
    parameter int SEL_BASE = 32,
    localparam int IDX_W   = $clog2(NUM_PRED)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [IDX_W-1:0]    qp_idx,
    input  logic [NUM_PRED-1:0] pred_vals,
    input  logic [IMM_W-1:0]    sel_imm,
    input  logic                rel_nz,
    input  logic [2:0]          ctype,
    input  logic [IDX_W-1:0]    dest1,
    input  logic [IDX_W-1:0]    dest2,
    input  logic [FEAT_W-1:0]   feat_vec,
    output logic                out_valid,
    output logic                wr_en_a,
    output logic [IDX_W-1:0]    wr_idx_a,
    output logic                wr_data_a,
    output logic                wr_en_b,
    output logic [IDX_W-1:0]    wr_idx_b,
    output logic                wr_data_b,
    output logic                fault
);
    logic             avail;
    logic             qual;
    pwr_t             nx_a;
    pwr_t             nx_b;
    logic [IDX_W-1:0] nx_idx_a;
    logic [IDX_W-1:0] nx_idx_b;
    logic             nx_flt;

    tfp_select #(.FEAT_W(FEAT_W), .IMM_W(IMM_W), .SEL_BASE(SEL_BASE)) sel_i (
        .feat  (feat_vec),
        .imm   (sel_imm),
        .avail (avail)
    );

    tfp_qual #(.NUM_PRED(NUM_PRED), .IDX_W(IDX_W)) qual_i (
        .pred_vals (pred_vals),
        .qp_idx    (qp_idx),
        .qual      (qual)
    );

    tfp_route #(.IDX_W(IDX_W)) route_i (
        .qual   (qual),
        .avail  (avail),
        .rel_nz (rel_nz),
        .ctype  (ctype),
        .dest1  (dest1),
        .dest2  (dest2),
        .port_a (nx_a),
        .port_b (nx_b),
        .idx_a  (nx_idx_a),
        .idx_b  (nx_idx_b),
        .flt    (nx_flt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en_a   <= 1'b0;
            wr_idx_a  <= '0;
            wr_data_a <= 1'b0;
            wr_en_b   <= 1'b0;
            wr_idx_b  <= '0;
            wr_data_b <= 1'b0;
            fault     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en_a   <= in_valid & nx_a.en;
            wr_en_b   <= in_valid & nx_b.en;
            fault     <= in_valid & nx_flt;
            if (in_valid) begin
                wr_idx_a  <= nx_idx_a;
                wr_data_a <= nx_a.data;
                wr_idx_b  <= nx_idx_b;
                wr_data_b <= nx_b.data;
            end
        end
    end
endmodule

// File: rtl/tfp_unit_chk.sv
module tfp_unit_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       ctype,
    input logic             out_valid,
    input logic             wr_en_a,
    input logic [IDX_W-1:0] wr_idx_a,
    input logic             wr_data_a,
    input logic             wr_en_b,
    input logic [IDX_W-1:0] wr_idx_b,
    input logic             wr_data_b,
    input logic             fault
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wr_en_a && !wr_en_b && !fault));

    assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!wr_en_a && !wr_en_b));

    assert_p0_a_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en_a |-> (wr_idx_a != '0));

    assert_p0_b_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en_b |-> (wr_idx_b != '0));

    assert_or_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(ctype) == 3'd3 && wr_en_a) |-> wr_data_a);

    assert_andcm_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(ctype) == 3'd4 && wr_en_b) |-> !wr_data_b);

    assert_reserved_R12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(ctype) > 3'd4) |-> (!wr_en_a && !wr_en_b && !fault));
endmodule

bind tfp_unit tfp_unit_chk #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .ctype     (ctype),
    .out_valid (out_valid),
    .wr_en_a   (wr_en_a),
    .wr_idx_a  (wr_idx_a),
    .wr_data_a (wr_data_a),
    .wr_en_b   (wr_en_b),
    .wr_idx_b  (wr_idx_b),
    .wr_data_b (wr_data_b),
    .fault     (fault)
);

// File: tb/tfp_unit_tb_top.sv
`timescale 1ns/1ps
module tfp_unit_tb_top;
    localparam int NUM_PRED = 64;
    localparam int IDX_W    = 6;
    localparam int FEAT_W   = 64;
    localparam int IMM_W    = 5;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [IDX_W-1:0]    qp_idx = '0;
    logic [NUM_PRED-1:0] pred_vals = '0;
    logic [IMM_W-1:0]    sel_imm = '0;
    logic                rel_nz = 1'b0;
    logic [2:0]          ctype = '0;
    logic [IDX_W-1:0]    dest1 = 6'd1;
    logic [IDX_W-1:0]    dest2 = 6'd2;
    logic [FEAT_W-1:0]   feat_vec = '0;
    logic                out_valid, wr_en_a, wr_data_a, wr_en_b, wr_data_b, fault;
    logic [IDX_W-1:0]    wr_idx_a, wr_idx_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tfp_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .qp_idx(qp_idx),
        .pred_vals(pred_vals), .sel_imm(sel_imm), .rel_nz(rel_nz),
        .ctype(ctype), .dest1(dest1), .dest2(dest2), .feat_vec(feat_vec),
        .out_valid(out_valid), .wr_en_a(wr_en_a), .wr_idx_a(wr_idx_a),
        .wr_data_a(wr_data_a), .wr_en_b(wr_en_b), .wr_idx_b(wr_idx_b),
        .wr_data_b(wr_data_b), .fault(fault)
    );

    function automatic string auto_tag();
        bit q = (qp_idx == 0) ? 1'b1 : pred_vals[qp_idx];
        if (ctype > 3'd4) return "R12";
        if (dest1 == dest2 && (q || ctype == 3'd1)) return "R10";
        if (dest1 == 0 || dest2 == 0) return "R11";
        case (ctype)
            3'd0: return "R5";
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Drives one valid operation and compares the registered result one clock later.
    task automatic op(input string tag);
        bit av, qv, t, sw, flt;
        bit e1, v1, e2, v2;
        bit xa_en, xa_d, xb_en, xb_d;
        logic [IDX_W-1:0] xa_i, xb_i;
        av = feat_vec[32 + sel_imm];
        qv = (qp_idx == 0) ? 1'b1 : pred_vals[qp_idx];
        t  = rel_nz ? av : !av;
        e1 = 0; v1 = 0; e2 = 0; v2 = 0;
        case (ctype)
            3'd0: if (qv) begin e1 = 1; v1 = t; e2 = 1; v2 = !t; end
            3'd1: begin e1 = 1; e2 = 1; v1 = qv & t; v2 = qv & !t; end
            3'd2: if (qv && !t) begin e1 = 1; e2 = 1; v1 = 0; v2 = 0; end
            3'd3: if (qv && t) begin e1 = 1; e2 = 1; v1 = 1; v2 = 1; end
            3'd4: if (qv && t) begin e1 = 1; e2 = 1; v1 = 1; v2 = 0; end
            default: ;
        endcase
        flt = (ctype <= 3'd4) && (dest1 == dest2) && (qv || ctype == 3'd1);
        if (flt) begin e1 = 0; e2 = 0; end
        if (dest1 == 0) e1 = 0;
        if (dest2 == 0) e2 = 0;
        sw = (ctype <= 3'd1) && rel_nz;
        xa_i = sw ? dest2 : dest1;  xb_i = sw ? dest1 : dest2;
        xa_en = sw ? e2 : e1;       xb_en = sw ? e1 : e2;
        xa_d = sw ? v2 : v1;        xb_d = sw ? v1 : v2;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b1 || fault !== flt || wr_en_a !== xa_en || wr_en_b !== xb_en
            || wr_idx_a !== xa_i || wr_idx_b !== xb_i
            || (xa_en && wr_data_a !== xa_d) || (xb_en && wr_data_b !== xb_d)) begin
            n_bad++;
            $display("FAIL %s: act v=%b f=%b A=%b/%0d/%b B=%b/%0d/%b exp f=%b A=%b/%0d/%b B=%b/%0d/%b",
                     tag, out_valid, fault, wr_en_a, wr_idx_a, wr_data_a, wr_en_b, wr_idx_b, wr_data_b,
                     flt, xa_en, xa_i, xa_d, xb_en, xb_i, xb_d);
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0;
        ctype = 3'd3;
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || wr_en_a !== 1'b0 || wr_en_b !== 1'b0 || fault !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: act v=%b ea=%b eb=%b f=%b exp all 0", tag, out_valid, wr_en_a, wr_en_b, fault);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;  // driven during reset on purpose
        ctype = 3'd1; dest1 = 6'd3; dest2 = 6'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid !== 0 || wr_en_a !== 0 || wr_en_b !== 0 || fault !== 0) begin
            n_bad++;
            $display("FAIL R1: act v=%b ea=%b eb=%b f=%b exp all 0", out_valid, wr_en_a, wr_en_b, fault);
        end
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        idle("R2");

        // Sweep every legal type, both senses, bit set/clear, qualifier true.
        pred_vals = 64'h0000_0000_0000_0010;
        for (int ct = 0; ct < 5; ct++)
            for (int nz = 0; nz < 2; nz++)
                for (int b = 0; b < 2; b++) begin
                    ctype = 3'(ct); rel_nz = nz[0]; sel_imm = 5'd1;
                    feat_vec = b[0] ? 64'h0000_0002_0000_0000 : 64'h0;
                    qp_idx = 6'd4; dest1 = 6'd7; dest2 = 6'd9;
                    op(auto_tag());
                end
        // Qualifier false: plain writes nothing (R5), unconditional clears (R6).
        qp_idx = 6'd5; ctype = 3'd0; rel_nz = 1'b1; op("R5");
        ctype = 3'd1; op("R6");
        ctype = 3'd3; feat_vec = '1; op("R8");
        // R4: index 0 reads as one even when the supplied bit 0 is zero.
        pred_vals = '0; qp_idx = 6'd0; ctype = 3'd3; op("R4");
        // R3: low bits only; bit 32 clear, OR/non-zero must not write.
        feat_vec = 64'h0000_0000_FFFF_FFFF; sel_imm = 5'd0; rel_nz = 1'b1; op("R3");
        // R3: top of the window, bit 63.
        feat_vec = 64'h8000_0000_0000_0000; sel_imm = 5'd31; op("R3");
        // R10: same destinations.
        dest1 = 6'd12; dest2 = 6'd12; ctype = 3'd0; op("R10");
        pred_vals = 64'h0; qp_idx = 6'd8; op("R10");
        ctype = 3'd1; op("R10");
        // R11: destination 0 suppressed.
        qp_idx = 6'd0; dest1 = 6'd0; dest2 = 6'd20; ctype = 3'd0; rel_nz = 1'b0; op("R11");
        ctype = 3'd1; rel_nz = 1'b1; op("R11");
        // R12: reserved codes.
        dest1 = 6'd5; dest2 = 6'd5;
        for (int ct = 5; ct < 8; ct++) begin ctype = 3'(ct); op("R12"); end
        idle("R2");

        for (int i = 0; i < 600; i++) begin
            qp_idx    = 6'($urandom_range(0, 63));
            pred_vals = {$urandom, $urandom};
            sel_imm   = 5'($urandom);
            rel_nz    = 1'($urandom);
            ctype     = 3'($urandom_range(0, 7));
            dest1     = 6'($urandom_range(0, 15));
            dest2     = ($urandom_range(0, 5) == 0) ? dest1 : 6'($urandom_range(0, 15));
            feat_vec  = {$urandom, $urandom};
            if (($urandom_range(0, 9)) == 0) idle("R2");
            else op(auto_tag());
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule